// File: doc/BRIEF.md
# Split-Width Translation Control Registers

This block holds the two 64-bit configuration words of an address translation unit: a control word (enable, page-size and table-size fields, decoded elsewhere) and the base address of the translation table in memory. Both words drive the translation logic continuously through dedicated output ports. A simple single-cycle bus reaches them, and each access is marked as either 64 bits or 32 bits wide.

A 64-bit word can also be reached as two 32-bit halves in big-endian order. The half at the word's own offset is bits 63:32, and the half at offset plus 4 is bits 31:0. This lets a 32-bit host program the registers one half at a time without disturbing the other half. A flush location accepts writes and has no storage behind it. Any other offset is silent: it reads as zero and ignores writes. Read data is captured into a register and appears on the cycle after the read strobe.

Top module: `xlat_csr_bank`

## Requirements
- R1: The control word sits at byte offset 0x00 and the table base word at 0x08. Their current values are always present on `ctrl_q` and `tbase_q`.
- R2: A write with `bus_wide`=1 at a word's own offset replaces all 64 bits with `bus_wdata`. A read with `bus_wide`=1 there returns all 64 bits.
- R3: A write with `bus_wide`=0 at a word's own offset loads `bus_wdata[31:0]` into bits 63:32 and leaves bits 31:0 unchanged.
- R4: A write at a word's offset plus 4, of either width, loads `bus_wdata[31:0]` into bits 31:0 and leaves bits 63:32 unchanged.
- R5: A read with `bus_wide`=0 at a word's own offset returns bits 63:32 on `bus_rdata[31:0]`. A read at offset plus 4 returns bits 31:0 on `bus_rdata[31:0]`. In both cases `bus_rdata[63:32]` is zero.
- R6: Writes to the flush location (0x10 or 0x14) change no stored state, and reads from it return zero.
- R7: An offset of 0x18 or above, or any offset with bits 1:0 not zero, reads as zero, and writes to it are ignored.
- R8: Reset clears both words and `bus_rdata` to zero, which leaves translation disabled.
- R9: `bus_rdata` takes the read result on the clock edge that samples `bus_rd`, and holds its value in every cycle without a read strobe.
- R10: A read and a write to the same word in the same cycle return the value the word held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wide | input | 1 | 1 = 64-bit access, 0 = 32-bit access |
| bus_wdata | input | 64 | Write data; 32-bit writes use bits 31:0 |
| bus_rdata | output | 64 | Registered read data |
| ctrl_q | output | 64 | Control word to the translation logic |
| tbase_q | output | 64 | Table base word to the translation logic |

## Verification
The hardest case to reach is a sequence of half writes mixed with full writes to the same word, where one half has to survive while the other changes. A single directed write shows little, because a wrong merge only appears when the untouched half already holds a distinctive value. The random stimulus uses fresh data on every access and mixes widths and offsets, including misaligned and flush offsets, so half writes regularly land on words whose other half was set by an earlier access. Directed cases cover same-cycle read and write, and reset in the middle of a run.

// File: rtl/xlat_csr_pkg.sv
package xlat_csr_pkg;
  localparam int unsigned WORD_W = 64;
  localparam int unsigned HALF_W = WORD_W / 2;

  // Kind of value a read returns for the decoded offset.
  typedef enum logic [1:0] {
    RSEL_ZERO  = 2'd0,
    RSEL_FULL  = 2'd1,
    RSEL_UPPER = 2'd2,
    RSEL_LOWER = 2'd3
  } rsel_e;
endpackage

// File: rtl/xlat_csr_decode.sv
module xlat_csr_decode
  import xlat_csr_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned NUM_REGS = 2,
  localparam int unsigned WI_W    = ADDR_W - 3,
  localparam int unsigned IDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic               wr,
  input  logic [ADDR_W-1:0]  addr,
  input  logic               wide,
  input  logic [WORD_W-1:0]  wdata,
  output logic [NUM_REGS-1:0] wr_hi_en,
  output logic [NUM_REGS-1:0] wr_lo_en,
  output logic [HALF_W-1:0]  hi_word,
  output logic [HALF_W-1:0]  lo_word,
  output logic [IDX_W-1:0]   rd_idx,
  output rsel_e              rd_kind
);
  logic [WI_W-1:0] word_idx;
  logic            aligned;
  logic            lo_sel;
  logic            hit;

  assign word_idx = addr[ADDR_W-1:3];
  assign aligned  = (addr[1:0] == 2'b00);
  assign lo_sel   = addr[2];
  assign hit      = aligned && (word_idx < WI_W'(NUM_REGS));

  // A full-width write at the word offset feeds the upper half from the
  // top of the bus; a narrow one feeds it from the low 32 bits.
  assign hi_word = wide ? wdata[WORD_W-1:HALF_W] : wdata[HALF_W-1:0];
  assign lo_word = wdata[HALF_W-1:0];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_en
    logic sel;
    assign sel         = wr && aligned && (word_idx == WI_W'(i));
    assign wr_hi_en[i] = sel && !lo_sel;
    assign wr_lo_en[i] = sel && (lo_sel || wide);
  end

  assign rd_idx = word_idx[IDX_W-1:0];

  always_comb begin
    if (!hit) begin
      rd_kind = RSEL_ZERO;
    end else if (lo_sel) begin
      rd_kind = RSEL_LOWER;
    end else if (wide) begin
      rd_kind = RSEL_FULL;
    end else begin
      rd_kind = RSEL_UPPER;
    end
  end
endmodule

// File: rtl/xlat_csr_word.sv
module xlat_csr_word
  import xlat_csr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hi_en,
  input  logic              lo_en,
  input  logic [HALF_W-1:0] hi_word,
  input  logic [HALF_W-1:0] lo_word,
  output logic [WORD_W-1:0] q
);
  logic [HALF_W-1:0] hi_q, lo_q;
  logic [HALF_W-1:0] hi_d, lo_d;

  always_comb begin
    hi_d = hi_en ? hi_word : hi_q;
    lo_d = lo_en ? lo_word : lo_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= '0;
      lo_q <= '0;
    end else begin
      if (hi_en) hi_q <= hi_d;
      if (lo_en) lo_q <= lo_d;
    end
  end

  assign q = {hi_q, lo_q};
endmodule

// File: rtl/xlat_csr_rdport.sv
module xlat_csr_rdport
  import xlat_csr_pkg::*;
#(
  parameter int unsigned NUM_REGS = 2,
  localparam int unsigned IDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       rd_stb,
  input  rsel_e                      rd_kind,
  input  logic [IDX_W-1:0]           rd_idx,
  input  logic [NUM_REGS*WORD_W-1:0] words,
  output logic [WORD_W-1:0]          rdata
);
  logic [WORD_W-1:0] sel_word;
  logic [WORD_W-1:0] rdata_d;

  always_comb begin
    sel_word = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (rd_idx == IDX_W'(i)) sel_word = words[i*WORD_W +: WORD_W];
    end
    unique case (rd_kind)
      RSEL_FULL:  rdata_d = sel_word;
      RSEL_UPPER: rdata_d = {{HALF_W{1'b0}}, sel_word[WORD_W-1:HALF_W]};
      RSEL_LOWER: rdata_d = {{HALF_W{1'b0}}, sel_word[HALF_W-1:0]};
      default:    rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= '0;
    end else if (rd_stb) begin
      rdata <= rdata_d;
    end
  end
endmodule

// File: rtl/xlat_csr_bank.sv
module xlat_csr_bank
  import xlat_csr_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wide,
  input  logic [63:0]       bus_wdata,
  output logic [63:0]       bus_rdata,
  output logic [63:0]       ctrl_q,
  output logic [63:0]       tbase_q
);
  localparam int unsigned NUM_REGS = 2;
  localparam int unsigned IDX_W    = $clog2(NUM_REGS);

  logic [NUM_REGS-1:0]        wr_hi_en, wr_lo_en;
  logic [HALF_W-1:0]          hi_word, lo_word;
  logic [IDX_W-1:0]           rd_idx;
  rsel_e                      rd_kind;
  logic [NUM_REGS*WORD_W-1:0] words;

  xlat_csr_decode #(.ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS)) u_dec (
    .wr       (bus_wr),
    .addr     (bus_addr),
    .wide     (bus_wide),
    .wdata    (bus_wdata),
    .wr_hi_en (wr_hi_en),
    .wr_lo_en (wr_lo_en),
    .hi_word  (hi_word),
    .lo_word  (lo_word),
    .rd_idx   (rd_idx),
    .rd_kind  (rd_kind)
  );

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_word
    xlat_csr_word u_word (
      .clk     (clk),
      .rst_n   (rst_n),
      .hi_en   (wr_hi_en[i]),
      .lo_en   (wr_lo_en[i]),
      .hi_word (hi_word),
      .lo_word (lo_word),
      .q       (words[i*WORD_W +: WORD_W])
    );
  end

  xlat_csr_rdport #(.NUM_REGS(NUM_REGS)) u_rd (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_stb  (bus_rd),
    .rd_kind (rd_kind),
    .rd_idx  (rd_idx),
    .words   (words),
    .rdata   (bus_rdata)
  );

  assign ctrl_q  = words[WORD_W-1:0];
  assign tbase_q = words[2*WORD_W-1:WORD_W];
endmodule

// File: rtl/xlat_csr_bank_chk.sv
module xlat_csr_bank_chk #(
  parameter int unsigned ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wide,
  input logic [63:0]       bus_wdata,
  input logic [63:0]       bus_rdata,
  input logic [63:0]       ctrl_q,
  input logic [63:0]       tbase_q
);
  logic at_ctrl_hi, at_ctrl_lo, at_flush, far_off;
  assign at_ctrl_hi = (bus_addr == ADDR_W'(8'h00));
  assign at_ctrl_lo = (bus_addr == ADDR_W'(8'h04));
  assign at_flush   = (bus_addr == ADDR_W'(8'h10)) || (bus_addr == ADDR_W'(8'h14));
  assign far_off    = (bus_addr >= ADDR_W'(8'h18)) || (bus_addr[1:0] != 2'b00);

  assert_full_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_wide && at_ctrl_hi) |=> (ctrl_q == $past(bus_wdata)));

  assert_upper_half_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !bus_wide && at_ctrl_hi) |=>
      (ctrl_q[63:32] == $past(bus_wdata[31:0])) && (ctrl_q[31:0] == $past(ctrl_q[31:0])));

  assert_lower_half_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && at_ctrl_lo) |=>
      (ctrl_q[31:0] == $past(bus_wdata[31:0])) && (ctrl_q[63:32] == $past(ctrl_q[63:32])));

  assert_narrow_read_top_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !bus_wide) |=> (bus_rdata[63:32] == 32'h0));

  assert_flush_inert_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && at_flush) |=> ($stable(ctrl_q) && $stable(tbase_q)));

  assert_flush_read_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && at_flush) |=> (bus_rdata == 64'h0));

  assert_unmapped_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (far_off) |=> ($stable(ctrl_q) && $stable(tbase_q)));

  assert_unmapped_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && far_off) |=> (bus_rdata == 64'h0));

  assert_rdata_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_rd) |=> $stable(bus_rdata));

  assert_no_write_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_wr) |=> ($stable(ctrl_q) && $stable(tbase_q)));

  assert_read_before_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_wr && bus_wide && at_ctrl_hi) |=> (bus_rdata == $past(ctrl_q)));
endmodule

bind xlat_csr_bank xlat_csr_bank_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_addr  (bus_addr),
  .bus_wide  (bus_wide),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .ctrl_q    (ctrl_q),
  .tbase_q   (tbase_q)
);

// File: tb/xlat_csr_bank_tb.sv
module xlat_csr_bank_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr, bus_rd, bus_wide;
  logic [7:0]  bus_addr;
  logic [63:0] bus_wdata;
  logic [63:0] bus_rdata, ctrl_q, tbase_q;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [63:0] ctrl_m, base_m, rd_m;

  always #5 clk = ~clk;

  xlat_csr_bank #(.ADDR_W(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wide(bus_wide), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .ctrl_q(ctrl_q), .tbase_q(tbase_q)
  );

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic bit mapped(input logic [7:0] a);
    return (a[1:0] == 2'b00) && (a[7:3] < 5'd2);
  endfunction

  function automatic logic [63:0] model_read(input logic [7:0] a, input bit wide);
    logic [63:0] r;
    if (!mapped(a)) return 64'h0;
    r = (a[3] == 1'b0) ? ctrl_m : base_m;
    if (a[2]) return {32'h0, r[31:0]};
    if (wide) return r;
    return {32'h0, r[63:32]};
  endfunction

  function automatic logic [63:0] model_write(input logic [63:0] r, input logic [7:0] a,
                                              input bit wide, input logic [63:0] wd);
    logic [63:0] n = r;
    if (a[2]) n[31:0] = wd[31:0];
    else if (wide) n = wd;
    else n[63:32] = wd[31:0];
    return n;
  endfunction

  function automatic string tag_of(input logic [7:0] a, input bit wide, input bit wr);
    if (a[1:0] != 2'b00 || a >= 8'h18) return "R7";
    if (a >= 8'h10) return "R6";
    if (a[2]) return wr ? "R4" : "R5";
    if (wide) return "R2";
    return wr ? "R3" : "R5";
  endfunction

  // One access, driven at a falling edge and checked at the next one.
  task automatic access(input bit wr, input bit rd, input logic [7:0] a,
                        input bit wide, input logic [63:0] wd, input string req);
    if (rd) rd_m = model_read(a, wide);
    bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wide = wide; bus_wdata = wd;
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0;
    if (wr && mapped(a)) begin
      if (a[3] == 1'b0) ctrl_m = model_write(ctrl_m, a, wide, wd);
      else base_m = model_write(base_m, a, wide, wd);
    end
    check(req, "ctrl_q", ctrl_q, ctrl_m);
    check(req, "tbase_q", tbase_q, base_m);
    check(rd ? req : "R9", "bus_rdata", bus_rdata, rd_m);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : stim
    void'($urandom(32'd20240611));
    rst_n = 1'b0; bus_wr = 0; bus_rd = 0; bus_addr = 0; bus_wide = 0; bus_wdata = 0;
    ctrl_m = 0; base_m = 0; rd_m = 0;
    repeat (3) @(negedge clk);
    check("R8", "ctrl_q reset", ctrl_q, 64'h0);
    check("R8", "tbase_q reset", tbase_q, 64'h0);
    check("R8", "rdata reset", bus_rdata, 64'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: both words at their own offsets, seen on the outputs
    access(1, 0, 8'h00, 1, 64'h0123_4567_89AB_CDEF, "R1");
    access(1, 0, 8'h08, 1, 64'hFEDC_BA98_7654_3210, "R1");
    access(0, 1, 8'h08, 1, 64'h0, "R2");
    // R3/R4 halves, R5 narrow reads
    access(1, 0, 8'h00, 0, 64'hFFFF_FFFF_AAAA_5555, "R3");
    access(1, 0, 8'h0C, 0, 64'hFFFF_FFFF_1357_9BDF, "R4");
    access(1, 0, 8'h04, 1, 64'h1111_2222_3333_4444, "R4");
    access(0, 1, 8'h00, 0, 64'h0, "R5");
    access(0, 1, 8'h0C, 0, 64'h0, "R5");
    // R6 flush, R7 unmapped and misaligned
    access(1, 1, 8'h10, 1, 64'hDEAD_BEEF_DEAD_BEEF, "R6");
    access(1, 1, 8'h14, 0, 64'hDEAD_BEEF_DEAD_BEEF, "R6");
    access(1, 1, 8'h18, 1, 64'hCAFE_CAFE_CAFE_CAFE, "R7");
    access(1, 1, 8'h01, 1, 64'hCAFE_CAFE_CAFE_CAFE, "R7");
    access(1, 1, 8'h0A, 0, 64'hCAFE_CAFE_CAFE_CAFE, "R7");
    // R9: hold across idle cycles
    access(0, 1, 8'h08, 1, 64'h0, "R9");
    access(0, 0, 8'h00, 1, 64'h0, "R9");
    access(0, 0, 8'h10, 0, 64'h0, "R9");
    // R10: read and write the same word together
    access(1, 1, 8'h00, 1, 64'h5A5A_5A5A_A5A5_A5A5, "R10");
    access(1, 1, 8'h0C, 0, 64'h0000_0000_7777_8888, "R10");

    for (int n = 0; n < 3000; n++) begin
      logic [7:0] a;
      bit wr, rd, wide;
      logic [63:0] wd;
      a    = ($urandom % 8 == 0) ? 8'($urandom % 32) : 8'(($urandom % 6) * 4);
      wr   = 1'($urandom);
      rd   = 1'($urandom);
      wide = 1'($urandom);
      wd   = {$urandom, $urandom};
      access(wr, rd, a, wide, wd, tag_of(a, wide, wr));
    end

    // R8: reset in mid-run clears everything
    access(1, 0, 8'h00, 1, 64'h8000_0000_0000_0001, "R2");
    access(0, 1, 8'h00, 1, 64'h0, "R2");
    rst_n = 1'b0;
    #2;
    check("R8", "ctrl_q mid reset", ctrl_q, 64'h0);
    check("R8", "tbase_q mid reset", tbase_q, 64'h0);
    check("R8", "rdata mid reset", bus_rdata, 64'h0);
    @(negedge clk);
    rst_n = 1'b1;
    ctrl_m = 0; base_m = 0; rd_m = 0;
    @(negedge clk);
    access(0, 1, 8'h04, 0, 64'h0, "R8");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule